// File: doc/BRIEF.md
# Dual-Stack Monitor Interrupt Controller

This block raises interrupts for a bus monitor that records traffic into two circular stacks in memory, one for command records and one for data records. The block holds the current pointer of each stack. Each pointer-advance pulse moves that pointer forward by one word. When the pointer passes the stack's last address it wraps back to the stack's first address. Two conditions are detected on each stack: the wrap itself, and the arrival of the pointer at a host-programmed match address. The monitor's message logic reports the end of each message with a pulse, together with a broadcast flag and the message-error bit taken from the terminal's status word.

Each detected condition can set one bit of a pending register. A bit is set only when the matching bit of an enable register is 1. Pending bits stay set until the host clears them with a write-one-to-clear access. A single interrupt line is active while any pending bit is set. Two bit positions are reserved: they cannot be enabled and they never read as pending. Bus decoding and the storage of messages are handled elsewhere.

Top module: `stack_mon_irq`

## Requirements
- R1: Each stack pointer loads its stack base address in reset. On an advance pulse it moves to pointer+1, or to the base address when it was equal to the limit (last) address. Without a pulse it holds.
- R2: The command rollover bit (bit 5) sets when a command advance wraps the pointer from the limit back to the base.
- R3: The data rollover bit (bit 4) sets when a data advance wraps the pointer from the limit back to the base.
- R4: The command match bit (bit 3) sets when a command advance leaves the pointer equal to the command match address. This includes a wrap onto a base that equals the match address.
- R5: The data match bit (bit 2) sets when a data advance leaves the pointer equal to the data match address.
- R6: The message error bit (bit 1) sets on a message-done pulse only when the broadcast flag is 0 and the status message-error flag is 1. The message-error flag without a done pulse has no effect.
- R7: The end-of-message bit (bit 0) sets on every message-done pulse, whatever the broadcast and error flags are.
- R8: Bits 7 and 6 always read 0 in both the enable register and the pending register, whatever value is written.
- R9: A pending bit latches only if its enable bit was 1 in the cycle of the event. An event while the bit is disabled leaves the pending bit at 0. A later enable does not recover that event.
- R10: Writing 1 to a bit through the clear port clears that pending bit. Writing 0 leaves the bit unchanged.
- R11: The interrupt output is 1 exactly when any pending bit is 1. It stays 1 until the last pending bit is cleared.
- R12: When an enabled event and a clear hit the same bit in the same cycle, the bit stays set.
- R13: After reset the enable register, the pending register and the interrupt output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_adv | input | 1 | Command stack pointer advance pulse |
| cmd_base | input | AW | Command stack first address |
| cmd_limit | input | AW | Command stack last address |
| cmd_mark | input | AW | Command stack match address |
| cmd_ptr | output | AW | Current command stack pointer |
| dat_adv | input | 1 | Data stack pointer advance pulse |
| dat_base | input | AW | Data stack first address |
| dat_limit | input | AW | Data stack last address |
| dat_mark | input | AW | Data stack match address |
| dat_ptr | output | AW | Current data stack pointer |
| msg_done | input | 1 | Message completed pulse |
| msg_bcast | input | 1 | Completed message was broadcast |
| msg_me | input | 1 | Message-error flag of the terminal status word |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write value |
| clr_we | input | 1 | Pending clear strobe |
| clr_wdata | input | 8 | Write-one-to-clear mask |
| irq_enable | output | 8 | Enable register contents |
| irq_pending | output | 8 | Pending register contents |
| irq | output | 1 | Interrupt request |

## Verification
Several functions of this block can fall in the same clock cycle, and the bench triggers each such overlap on purpose. The main case is a host clear that hits a bit in the same cycle as a new event on that bit; the bench drives a message-done pulse and a clear of bit 0 together and expects the bit to stay set. It also wraps a stack onto a base address that equals its match address, so that rollover and match set in one cycle. It advances both stacks together and clears bits one at a time while the interrupt line must stay high. A behavioural model of pointers, enables and pending bits is compared with every output on every clock, so an overlap that drops or duplicates a bit is found in the cycle where it happens.

// File: rtl/stack_mon_irq_pkg.sv
package stack_mon_irq_pkg;

    localparam int IRQ_W = 8;

    // Bit positions inside the enable and pending registers
    localparam int B_EOM    = 0;
    localparam int B_MERR   = 1;
    localparam int B_DMATCH = 2;
    localparam int B_CMATCH = 3;
    localparam int B_DROLL  = 4;
    localparam int B_CROLL  = 5;

    localparam logic [IRQ_W-1:0] USED_MASK = 8'h3F;

    typedef logic [IRQ_W-1:0] irq_vec_t;

    typedef struct packed {
        logic roll;
        logic match;
    } stk_evt_t;

    typedef struct packed {
        logic merr;
        logic eom;
    } msg_evt_t;

    function automatic irq_vec_t pack_events(stk_evt_t c, stk_evt_t d, msg_evt_t m);
        irq_vec_t v;
        v           = '0;
        v[B_CROLL]  = c.roll;
        v[B_CMATCH] = c.match;
        v[B_DROLL]  = d.roll;
        v[B_DMATCH] = d.match;
        v[B_MERR]   = m.merr;
        v[B_EOM]    = m.eom;
        return v;
    endfunction

endpackage

// File: rtl/smi_stack_ptr.sv
module smi_stack_ptr
    import stack_mon_irq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] mark,
    output logic [AW-1:0] ptr,
    output stk_evt_t      evt
);

    logic          at_end;
    logic [AW-1:0] nxt;

    always_comb begin
        at_end    = (ptr == limit);
        nxt       = at_end ? base : ptr + AW'(1);
        evt.roll  = adv && at_end;
        evt.match = adv && (nxt == mark);
    end

    always_ff @(posedge clk) begin
        if (rst)      ptr <= base;
        else if (adv) ptr <= nxt;
    end

    // R1: wrap from limit back to base
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr == limit) |=> (ptr == $past(base)));

    // R1: ordinary step
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr != limit) |=> (ptr == $past(ptr) + AW'(1)));

    // R1: hold without an advance
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr));

    // R4: a reported match leaves the pointer on the match address
    a_r4_match_lands: assert property (@(posedge clk) disable iff (rst)
        evt.match |=> (ptr == $past(mark)));

endmodule

// File: rtl/smi_msg_evt.sv
module smi_msg_evt
    import stack_mon_irq_pkg::*;
(
    input  logic     done,
    input  logic     bcast,
    input  logic     me,
    output msg_evt_t evt
);

    always_comb begin
        evt.eom  = done;
        evt.merr = done && !bcast && me;
    end

endmodule

// File: rtl/smi_irq_bank.sv
module smi_irq_bank
    import stack_mon_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set_vec,
    input  logic     en_we,
    input  irq_vec_t en_wdata,
    input  logic     clr_we,
    input  irq_vec_t clr_wdata,
    output irq_vec_t enable,
    output irq_vec_t pending,
    output logic     irq
);

    irq_vec_t clr_mask;
    assign clr_mask = clr_we ? clr_wdata : '0;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        if (USED_MASK[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    enable[i]  <= 1'b0;
                    pending[i] <= 1'b0;
                end else begin
                    if (en_we) enable[i] <= en_wdata[i];
                    // a new event overrides a clear in the same cycle
                    pending[i] <= (pending[i] && !clr_mask[i]) ||
                                  (set_vec[i] && enable[i]);
                end
            end
        end else begin : g_rsvd
            assign enable[i]  = 1'b0;
            assign pending[i] = 1'b0;
        end
    end

    assign irq = |pending;

    // R8: reserved positions never hold a 1
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        ((pending | enable) & ~USED_MASK) == '0);

    // R9: a disabled event does not latch
    a_r9_gated: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_vec & ~enable & ~pending) & pending) == '0));

    // R10: an uncleared bit holds
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pending & ~clr_mask) & ~pending) == '0));

    // R12: an enabled event always lands, even against a clear
    a_r12_event_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_vec & enable) & ~pending) == '0));

    // R11: line stays up while some pending bit survives the clear
    a_r11_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && (pending & ~clr_mask) != '0) |=> irq);

endmodule

// File: rtl/stack_mon_irq.sv
module stack_mon_irq
    import stack_mon_irq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_adv,
    input  logic [AW-1:0] cmd_base,
    input  logic [AW-1:0] cmd_limit,
    input  logic [AW-1:0] cmd_mark,
    output logic [AW-1:0] cmd_ptr,
    input  logic          dat_adv,
    input  logic [AW-1:0] dat_base,
    input  logic [AW-1:0] dat_limit,
    input  logic [AW-1:0] dat_mark,
    output logic [AW-1:0] dat_ptr,
    input  logic          msg_done,
    input  logic          msg_bcast,
    input  logic          msg_me,
    input  logic          en_we,
    input  logic [7:0]    en_wdata,
    input  logic          clr_we,
    input  logic [7:0]    clr_wdata,
    output logic [7:0]    irq_enable,
    output logic [7:0]    irq_pending,
    output logic          irq
);

    localparam int NSTK = 2;   // index 0: command, 1: data

    logic [NSTK-1:0]         adv_v;
    logic [NSTK-1:0][AW-1:0] base_v, limit_v, mark_v, ptr_v;
    stk_evt_t [NSTK-1:0]     sevt;
    msg_evt_t                mevt;
    irq_vec_t                set_vec;

    assign adv_v   = {dat_adv, cmd_adv};
    assign base_v  = {dat_base, cmd_base};
    assign limit_v = {dat_limit, cmd_limit};
    assign mark_v  = {dat_mark, cmd_mark};

    for (genvar s = 0; s < NSTK; s++) begin : g_stk
        smi_stack_ptr #(.AW(AW)) u_ptr (
            .clk   (clk),
            .rst   (rst),
            .adv   (adv_v[s]),
            .base  (base_v[s]),
            .limit (limit_v[s]),
            .mark  (mark_v[s]),
            .ptr   (ptr_v[s]),
            .evt   (sevt[s])
        );
    end

    assign cmd_ptr = ptr_v[0];
    assign dat_ptr = ptr_v[1];

    smi_msg_evt u_msg (
        .done  (msg_done),
        .bcast (msg_bcast),
        .me    (msg_me),
        .evt   (mevt)
    );

    assign set_vec = pack_events(sevt[0], sevt[1], mevt);

    smi_irq_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .enable    (irq_enable),
        .pending   (irq_pending),
        .irq       (irq)
    );

    // R6: a broadcast message never marks a message error
    a_r6_bcast_no_merr: assert property (@(posedge clk) disable iff (rst)
        (msg_done && msg_bcast && !irq_pending[B_MERR]) |=> !irq_pending[B_MERR]);

    // R7: an enabled completion is always seen
    a_r7_eom_seen: assert property (@(posedge clk) disable iff (rst)
        (msg_done && irq_enable[B_EOM]) |=> irq_pending[B_EOM]);

endmodule

// File: tb/stack_mon_irq_test.sv
module stack_mon_irq_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_adv = 1'b0, dat_adv = 1'b0;
    logic [AW-1:0] cmd_base = 16'h0010, cmd_limit = 16'h0014, cmd_mark = 16'h0012;
    logic [AW-1:0] dat_base = 16'h0040, dat_limit = 16'h0042, dat_mark = 16'h0040;
    logic          msg_done = 1'b0, msg_bcast = 1'b0, msg_me = 1'b0;
    logic          en_we = 1'b0, clr_we = 1'b0;
    logic [7:0]    en_wdata = 8'h00, clr_wdata = 8'h00;
    logic [AW-1:0] cmd_ptr, dat_ptr;
    logic [7:0]    irq_enable, irq_pending;
    logic          irq;

    stack_mon_irq #(.AW(AW)) uut (
        .clk(clk), .rst(rst),
        .cmd_adv(cmd_adv), .cmd_base(cmd_base), .cmd_limit(cmd_limit), .cmd_mark(cmd_mark), .cmd_ptr(cmd_ptr),
        .dat_adv(dat_adv), .dat_base(dat_base), .dat_limit(dat_limit), .dat_mark(dat_mark), .dat_ptr(dat_ptr),
        .msg_done(msg_done), .msg_bcast(msg_bcast), .msg_me(msg_me),
        .en_we(en_we), .en_wdata(en_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
        .irq_enable(irq_enable), .irq_pending(irq_pending), .irq(irq)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string cur    = "R13";
    bit    started = 0;

    // behavioural reference
    logic [AW-1:0] m_c, m_d;
    logic [7:0]    m_e, m_p, m_set;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_c = cmd_base; m_d = dat_base; m_e = 8'h00; m_p = 8'h00;
            started = 1;
        end else begin
            m_set = 8'h00;
            if (cmd_adv) begin
                if (m_c == cmd_limit) begin m_c = cmd_base; m_set |= 8'h20; end
                else m_c = m_c + 1;
                if (m_c == cmd_mark) m_set |= 8'h08;
            end
            if (dat_adv) begin
                if (m_d == dat_limit) begin m_d = dat_base; m_set |= 8'h10; end
                else m_d = m_d + 1;
                if (m_d == dat_mark) m_set |= 8'h04;
            end
            if (msg_done) begin
                m_set |= 8'h01;
                if (!msg_bcast && msg_me) m_set |= 8'h02;
            end
            m_p = ((m_p & ~(clr_we ? clr_wdata : 8'h00)) | (m_set & m_e)) & 8'h3F;
            if (en_we) m_e = en_wdata & 8'h3F;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (started) begin
            check(cmd_ptr == m_c, cur, "cmd_ptr", 32'(cmd_ptr), 32'(m_c));
            check(dat_ptr == m_d, cur, "dat_ptr", 32'(dat_ptr), 32'(m_d));
            check(irq_enable == m_e, cur, "enable", 32'(irq_enable), 32'(m_e));
            check(irq_pending == m_p, cur, "pending", 32'(irq_pending), 32'(m_p));
            check(irq == (m_p != 0), cur, "irq", 32'(irq), 32'(m_p != 0));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle();
        cmd_adv = 0; dat_adv = 0; msg_done = 0; msg_bcast = 0; msg_me = 0;
        en_we = 0; clr_we = 0; en_wdata = 0; clr_wdata = 0;
    endtask

    task automatic clear(input logic [7:0] m);
        clr_we = 1; clr_wdata = m; tick(1); idle();
    endtask

    task automatic msg(input bit b, input bit e);
        msg_done = 1; msg_bcast = b; msg_me = e; tick(1); idle();
    endtask

    initial begin
        tick(3);
        rst = 0;
        cur = "R13";
        tick(1);
        check(irq_pending == 0 && irq_enable == 0 && !irq, "R13", "reset state",
              32'({irq_enable, irq_pending}), 32'h0);
        check(cmd_ptr == 16'h0010, "R1", "cmd reset ptr", 32'(cmd_ptr), 32'h10);

        // events while disabled
        cur = "R9";
        cmd_adv = 1; msg_done = 1; msg_me = 1; tick(1); idle();
        en_we = 1; en_wdata = 8'hFF; tick(1); idle();
        check(irq_pending == 0, "R9", "disabled events lost", 32'(irq_pending), 32'h0);
        cur = "R8";
        check(irq_enable == 8'h3F, "R8", "reserved enable", 32'(irq_enable), 32'h3F);

        // command stack: 11->12 match, 13, 14, wrap 10, 11
        cur = "R4";
        cmd_adv = 1; tick(1); idle();
        check(irq_pending == 8'h08, "R4", "cmd match", 32'(irq_pending), 32'h08);
        cur = "R2";
        cmd_adv = 1; tick(3); idle();
        check(irq_pending == 8'h28 && cmd_ptr == 16'h0010, "R2", "cmd wrap",
              32'({cmd_ptr, irq_pending}), 32'h0010_0028);
        cur = "R1";
        cmd_adv = 1; tick(1); idle();
        check(cmd_ptr == 16'h0011, "R1", "cmd step after wrap", 32'(cmd_ptr), 32'h11);
        clear(8'hFF);

        // data stack wraps onto base == match: rollover and match together
        cur = "R3";
        dat_adv = 1; tick(2); idle();
        check(irq_pending == 0, "R5", "no early data match", 32'(irq_pending), 32'h0);
        dat_adv = 1; tick(1); idle();
        check(irq_pending == 8'h14, "R3", "data wrap+match", 32'(irq_pending), 32'h14);
        cur = "R5";
        clear(8'hFF);
        // both stacks advance together
        cmd_adv = 1; dat_adv = 1; tick(4); idle();
        clear(8'hFF);

        // message events
        cur = "R6";
        msg(1, 1);
        check(irq_pending == 8'h01, "R6", "broadcast no error", 32'(irq_pending), 32'h01);
        clear(8'hFF);
        msg(0, 1);
        check(irq_pending == 8'h03, "R6", "error set", 32'(irq_pending), 32'h03);
        clear(8'hFF);
        msg_me = 1; tick(1); idle();
        check(irq_pending == 0, "R6", "me without done", 32'(irq_pending), 32'h0);
        cur = "R7";
        msg(0, 0);
        check(irq_pending == 8'h01, "R7", "eom only", 32'(irq_pending), 32'h01);

        // clears
        cur = "R10";
        msg(0, 1);
        clear(8'h00);
        check(irq_pending == 8'h03, "R10", "write zero ignored", 32'(irq_pending), 32'h03);
        cur = "R11";
        clear(8'h01);
        check(irq && irq_pending == 8'h02, "R11", "irq held", 32'({irq, irq_pending}), 32'h102);
        clear(8'h02);
        check(!irq, "R11", "irq dropped", 32'(irq), 32'h0);

        // event and clear on the same bit
        cur = "R12";
        msg(0, 0);
        msg_done = 1; clr_we = 1; clr_wdata = 8'h01; tick(1); idle();
        check(irq_pending == 8'h01, "R12", "event beats clear", 32'(irq_pending), 32'h01);
        clear(8'h01);

        // reserved writes and partial enable
        cur = "R8";
        en_we = 1; en_wdata = 8'hC1; tick(1); idle();
        check(irq_enable == 8'h01, "R8", "reserved masked", 32'(irq_enable), 32'h01);
        cur = "R9";
        cmd_adv = 1; tick(5); idle();
        msg(0, 1);
        check(irq_pending == 8'h01, "R9", "only enabled bit", 32'(irq_pending), 32'h01);
        clear(8'hC0);
        check(irq_pending == 8'h01, "R8", "clear reserved no effect", 32'(irq_pending), 32'h01);
        tick(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule